// File: doc/BRIEF.md
# Nonvolatile Store Trigger Controller

This block decides when the contents of a battery-free SRAM are copied into their nonvolatile shadow cells, and it runs that copy in order. Three sources can ask for a copy. The first is a power-fail flag from an external supply comparator; its trip point is nominally 2.65 V. The second is an active-low request on a shared open-drain handshake pin. The third is a one-cycle request from a command decoder. A write-tracking latch remembers whether any SRAM write has completed since the last copy or restore. A copy is only started when that latch is set.

After reset the controller first runs a restore phase that loads the SRAM from the nonvolatile cells. SRAM access stays blocked until that phase ends. When a request is accepted, the controller blocks SRAM access and pulls the handshake pin low. It then waits a short grace window so that an SRAM cycle already in flight can finish. After the grace window it takes one of two paths:

- If the latch is set, it pulses a start strobe to the storage engine and holds the pin low for the whole store time.
- If the latch is clear, it drives the pin actively high for a few cycles and then lets it go.

Every duration is a parameter counted in clock cycles.

Top module: `store_ctrl`

## Requirements
- R1: While `rst` is high and for the first RECALL_CYC clock edges after it falls, `sram_inhibit` is 1, `hs_oe` is 0 and `store_start` is 0. At edge RECALL_CYC, `sram_inhibit` drops to 0. A software request or an SRAM write that arrives during this restore phase has no effect.
- R2: A hardware request is accepted when `hs_pin_in` is seen low on MIN_PULSE consecutive edges while the controller is idle. A low pulse seen on fewer edges is ignored.
- R3: A 1 on `sw_store_req` at an idle edge starts a store sequence.
- R4: A 1 on `pwr_fail` at an idle edge starts a store sequence only when `auto_store_en` is 1. The automatic path fires once per power-fail episode; it is re-armed when `pwr_fail` returns to 0. With `auto_store_en` at 0 the flag is ignored.
- R5: From the edge that accepts a request, for GRACE_CYC cycles, `sram_inhibit`=1 and the pin is driven low (`hs_oe`=1, `hs_out`=0). `store_start` stays 0 during this window. While idle, `hs_oe` is 0.
- R6: If the write latch is set when the grace window ends, `store_start` is 1 for exactly the first of STORE_CYC cycles. The pin stays driven low for all STORE_CYC cycles. After that, `hs_oe` and `sram_inhibit` both return to 0.
- R7: If the write latch is clear when the grace window ends, no store starts. Instead the pin is driven high (`hs_oe`=1, `hs_out`=1) for HIGH_CYC cycles, and then `hs_oe` and `sram_inhibit` return to 0.
- R8: Completing a store, or completing the restore phase, clears the write latch. A later request with no write in between therefore takes the R7 path.
- R9: Requests of any kind that arrive while a sequence is running are ignored. The sequence produces one strobe at most, and the controller then returns to idle.
- R10: `sram_write_done` sets the write latch only while the controller is idle or in the grace window. A write that completes during the grace window causes a store. A write pulse during a store is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; starts the restore phase |
| pwr_fail | input | 1 | Supply-below-trip flag from the external comparator |
| auto_store_en | input | 1 | 1 enables the automatic store on power fail |
| sw_store_req | input | 1 | One-cycle store request from the command decoder |
| sram_write_done | input | 1 | One-cycle pulse when an SRAM write completes |
| hs_pin_in | input | 1 | Sampled level of the open-drain handshake pin |
| hs_oe | output | 1 | 1 while the controller drives the handshake pin |
| hs_out | output | 1 | Level driven on the pin when `hs_oe` is 1 |
| sram_inhibit | output | 1 | 1 blocks normal SRAM reads and writes |
| store_start | output | 1 | One-cycle start strobe to the storage engine |

## Verification
All results are Moore outputs of the sequencer state. A request sampled at edge k therefore shows as a low drive right after edge k. The strobe appears right after edge k+GRACE_CYC. Release comes right after edge k+GRACE_CYC+STORE_CYC on the store path, or after edge k+GRACE_CYC+HIGH_CYC on the no-store path.

A hardware pulse is accepted on its MIN_PULSE-th low edge. Restore ends on edge RECALL_CYC after reset falls.

The bench drives inputs on falling edges and samples on the next falling edge. It walks the expected timeline one cycle at a time, so each output is compared in exactly the cycle it is due.

// File: rtl/stc_pkg.sv
package stc_pkg;

    typedef enum logic [2:0] {
        ST_RECALL  = 3'd0,
        ST_IDLE    = 3'd1,
        ST_DELAY   = 3'd2,
        ST_STORE   = 3'd3,
        ST_RELEASE = 3'd4
    } stc_state_e;

    typedef struct packed {
        logic oe;
        logic level;
        logic inhibit;
    } pin_ctl_t;

    // Moore decode of pin drive and access inhibit from the sequencer state
    function automatic pin_ctl_t decode_pins(stc_state_e s);
        pin_ctl_t p;
        p.inhibit = (s != ST_IDLE);
        p.oe      = (s == ST_DELAY) || (s == ST_STORE) || (s == ST_RELEASE);
        p.level   = (s == ST_RELEASE);
        return p;
    endfunction

    function automatic int max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/stc_pulse_filter.sv
module stc_pulse_filter #(
    parameter int MIN_PULSE = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic gate,
    input  logic pin_in,
    output logic hw_req
);
    localparam int W = (MIN_PULSE < 2) ? 1 : $clog2(MIN_PULSE);
    localparam logic [W-1:0] LAST = W'(MIN_PULSE - 1);

    logic [W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || gate || pin_in) begin
            low_cnt <= '0;
        end else if (low_cnt != LAST) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign hw_req = !gate && !pin_in && (low_cnt == LAST);
endmodule

// File: rtl/stc_wr_latch.sv
module stc_wr_latch (
    input  logic clk,
    input  logic rst,
    input  logic wr_done,
    input  logic wr_allow,
    input  logic clr,
    output logic dirty
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            dirty <= 1'b0;
        end else if (wr_done && wr_allow) begin
            dirty <= 1'b1;
        end
    end
endmodule

// File: rtl/stc_seq.sv
module stc_seq
    import stc_pkg::*;
#(
    parameter int RECALL_CYC = 4000000,
    parameter int GRACE_CYC  = 4,
    parameter int STORE_CYC  = 1600000,
    parameter int HIGH_CYC   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    input  logic       dirty,
    output stc_state_e state,
    output logic       store_start,
    output logic       dirty_clr
);
    localparam int MAXC = max4(RECALL_CYC, GRACE_CYC, STORE_CYC, HIGH_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] RECALL_END = CW'(RECALL_CYC - 1);
    localparam logic [CW-1:0] GRACE_END  = CW'(GRACE_CYC - 1);
    localparam logic [CW-1:0] STORE_END  = CW'(STORE_CYC - 1);
    localparam logic [CW-1:0] HIGH_END   = CW'(HIGH_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_RECALL;
            cnt         <= '0;
            store_start <= 1'b0;
        end else begin
            store_start <= 1'b0;
            case (state)
                ST_RECALL: begin
                    if (cnt == RECALL_END) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_IDLE: begin
                    cnt <= '0;
                    if (trig) state <= ST_DELAY;
                end
                ST_DELAY: begin
                    if (cnt == GRACE_END) begin
                        cnt <= '0;
                        if (dirty) begin
                            state       <= ST_STORE;
                            store_start <= 1'b1;
                        end else begin
                            state <= ST_RELEASE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STORE: begin
                    if (cnt == STORE_END) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RELEASE: begin
                    if (cnt == HIGH_END) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign dirty_clr = ((state == ST_RECALL) && (cnt == RECALL_END)) ||
                       ((state == ST_STORE)  && (cnt == STORE_END));
endmodule

// File: rtl/store_ctrl.sv
module store_ctrl
    import stc_pkg::*;
#(
    parameter int RECALL_CYC = 4000000,
    parameter int GRACE_CYC  = 4,
    parameter int STORE_CYC  = 1600000,
    parameter int HIGH_CYC   = 4,
    parameter int MIN_PULSE  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_fail,
    input  logic auto_store_en,
    input  logic sw_store_req,
    input  logic sram_write_done,
    input  logic hs_pin_in,
    output logic hs_oe,
    output logic hs_out,
    output logic sram_inhibit,
    output logic store_start
);
    stc_state_e state;
    pin_ctl_t   pins;
    logic       idle, hw_req, auto_fire, trig, dirty, dirty_clr, armed;

    assign idle      = (state == ST_IDLE);
    assign auto_fire = idle && pwr_fail && armed && auto_store_en;
    assign trig      = auto_fire || hw_req || sw_store_req;

    // one automatic store per power-fail episode
    always_ff @(posedge clk) begin
        if (rst || !pwr_fail) begin
            armed <= 1'b1;
        end else if (auto_fire) begin
            armed <= 1'b0;
        end
    end

    stc_pulse_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .gate   (!idle),
        .pin_in (hs_pin_in),
        .hw_req (hw_req)
    );

    stc_wr_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .wr_done  (sram_write_done),
        .wr_allow (idle || (state == ST_DELAY)),
        .clr      (dirty_clr),
        .dirty    (dirty)
    );

    stc_seq #(
        .RECALL_CYC (RECALL_CYC),
        .GRACE_CYC  (GRACE_CYC),
        .STORE_CYC  (STORE_CYC),
        .HIGH_CYC   (HIGH_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .trig        (trig),
        .dirty       (dirty),
        .state       (state),
        .store_start (store_start),
        .dirty_clr   (dirty_clr)
    );

    assign pins         = decode_pins(state);
    assign hs_oe        = pins.oe;
    assign hs_out       = pins.level;
    assign sram_inhibit = pins.inhibit;
endmodule

// File: rtl/store_ctrl_chk.sv
module store_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic sw_store_req,
    input logic hs_oe,
    input logic hs_out,
    input logic sram_inhibit,
    input logic store_start
);
    p_start_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        store_start |=> !store_start);

    p_start_busy_r6: assert property (@(posedge clk) disable iff (rst)
        store_start |-> (hs_oe && !hs_out && sram_inhibit));

    p_high_no_start_r7: assert property (@(posedge clk) disable iff (rst)
        (hs_oe && hs_out) |-> (sram_inhibit && !store_start));

    p_high_then_free_r7: assert property (@(posedge clk) disable iff (rst)
        (hs_oe && hs_out) |=> (!hs_oe || hs_out));

    p_idle_undriven_r5: assert property (@(posedge clk) disable iff (rst)
        !sram_inhibit |-> !hs_oe);

    p_sw_trigger_r3: assert property (@(posedge clk) disable iff (rst)
        (!sram_inhibit && sw_store_req) |=> (hs_oe && !hs_out && sram_inhibit));
endmodule

bind store_ctrl store_ctrl_chk u_chk (.*);

// File: tb/store_ctrl_tb.sv
`timescale 1ns/1ps
module store_ctrl_tb;
    localparam int RC = 20;
    localparam int GC = 3;
    localparam int SC = 12;
    localparam int HC = 2;
    localparam int MP = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_fail = 1'b0, auto_store_en = 1'b0, sw_store_req = 1'b0;
    logic sram_write_done = 1'b0, ext_low = 1'b0;
    logic hs_pin_in, hs_oe, hs_out, sram_inhibit, store_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit exp_dirty = 1'b0;

    always #2.5 clk = ~clk;

    // open-drain pin with pull-up: our drive wins, else external pull-down
    assign hs_pin_in = hs_oe ? hs_out : !ext_low;

    store_ctrl #(
        .RECALL_CYC(RC), .GRACE_CYC(GC), .STORE_CYC(SC),
        .HIGH_CYC(HC), .MIN_PULSE(MP)
    ) u_dut (
        .clk(clk), .rst(rst), .pwr_fail(pwr_fail), .auto_store_en(auto_store_en),
        .sw_store_req(sw_store_req), .sram_write_done(sram_write_done),
        .hs_pin_in(hs_pin_in), .hs_oe(hs_oe), .hs_out(hs_out),
        .sram_inhibit(sram_inhibit), .store_start(store_start)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(string req);
        chk(req, "sram_inhibit idle", sram_inhibit, 0);
        chk(req, "hs_oe idle", hs_oe, 0);
        chk(req, "store_start idle", store_start, 0);
    endtask

    // expected outcome of a sequence, from the requirements
    function automatic bit will_store(bit dirty, int inject);
        return dirty || (inject == 1);
    endfunction

    // called at the first sample point after the accepting edge
    // inject: 1 write in grace, 2 write during store, 3 sw request during store
    task automatic run_seq(bit stored, int inject, string req);
        for (int g = 0; g < GC; g++) begin
            chk("R5", "inhibit grace", sram_inhibit, 1);
            chk("R5", "oe grace", hs_oe, 1);
            chk("R5", "out grace", hs_out, 0);
            chk("R5", "start grace", store_start, 0);
            sram_write_done = (inject == 1 && g == 0);
            @(negedge clk);
        end
        sram_write_done = 1'b0;
        if (stored) begin
            for (int s = 0; s < SC; s++) begin
                chk(req, "start store", store_start, (s == 0) ? 1 : 0);
                chk("R6", "oe store", hs_oe, 1);
                chk("R6", "out store", hs_out, 0);
                chk("R6", "inhibit store", sram_inhibit, 1);
                sram_write_done = (inject == 2 && s == 1);
                sw_store_req    = (inject == 3 && s == 2);
                @(negedge clk);
            end
        end else begin
            for (int h = 0; h < HC; h++) begin
                chk(req, "oe high", hs_oe, 1);
                chk("R7", "out high", hs_out, 1);
                chk("R7", "start none", store_start, 0);
                @(negedge clk);
            end
        end
        sram_write_done = 1'b0;
        sw_store_req    = 1'b0;
        chk_idle(req);
        if (inject == 3) begin
            repeat (GC + 2) @(negedge clk);
            chk_idle("R9");
        end
        if (stored) exp_dirty = 1'b0;
    endtask

    task automatic do_write();
        sram_write_done = 1'b1;
        @(negedge clk);
        sram_write_done = 1'b0;
        exp_dirty = 1'b1;
    endtask

    task automatic fire_sw();
        sw_store_req = 1'b1;
        @(negedge clk);
        sw_store_req = 1'b0;
    endtask

    task automatic hw_pulse(int w);
        ext_low = 1'b1;
        repeat (w) @(negedge clk);
        ext_low = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R1 reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1", "inhibit in reset", sram_inhibit, 1);
            chk("R1", "oe in reset", hs_oe, 0);
        end
        rst = 1'b0;
        sw_store_req = 1'b1;
        sram_write_done = 1'b1;
        for (int i = 1; i <= RC; i++) begin
            @(negedge clk);
            sw_store_req = 1'b0;
            sram_write_done = 1'b0;
            chk("R1", "inhibit recall", sram_inhibit, (i < RC) ? 1 : 0);
            chk("R1", "oe recall", hs_oe, 0);
            chk("R1", "start recall", store_start, 0);
        end
        repeat (3) @(negedge clk);
        chk_idle("R1");

        // R8: restore cleared latch, R3 sw path, R7 no-store path
        fire_sw();
        run_seq(0, 0, "R8");
        // R6 store after write
        do_write();
        fire_sw();
        run_seq(1, 0, "R6");
        // R8 latch cleared by store
        fire_sw();
        run_seq(0, 0, "R8");

        // R2 short hardware pulse ignored, full pulse accepted
        do_write();
        hw_pulse(MP - 1);
        repeat (3) @(negedge clk);
        chk_idle("R2");
        hw_pulse(MP);
        run_seq(1, 0, "R2");

        // R4 disabled auto store ignored, enabled once per episode
        do_write();
        auto_store_en = 1'b0;
        pwr_fail = 1'b1;
        repeat (4) @(negedge clk);
        chk_idle("R4");
        pwr_fail = 1'b0;
        @(negedge clk);
        auto_store_en = 1'b1;
        pwr_fail = 1'b1;
        @(negedge clk);
        run_seq(1, 0, "R4");
        repeat (5) @(negedge clk);
        chk_idle("R4");
        pwr_fail = 1'b0;
        @(negedge clk);

        // R10 write in grace stores; write during store ignored
        fire_sw();
        run_seq(1, 1, "R10");
        do_write();
        fire_sw();
        run_seq(1, 2, "R10");
        fire_sw();
        run_seq(0, 0, "R10");
        // R9 request during store ignored
        do_write();
        fire_sw();
        run_seq(1, 3, "R9");

        // constrained random mix
        for (int it = 0; it < 40; it++) begin
            int  kind;
            int  inj;
            bit  trig;
            bit  st;
            if ($urandom % 2) do_write();
            kind = int'($urandom % 4);
            inj  = int'($urandom % 3);
            auto_store_en = 1'($urandom % 2);
            trig = (kind == 0) || (kind == 1) || (kind == 2 && auto_store_en);
            st   = will_store(exp_dirty, inj);
            case (kind)
                0: fire_sw();
                1: hw_pulse(MP);
                2: begin pwr_fail = 1'b1; @(negedge clk); end
                default: hw_pulse(1 + int'($urandom % (MP - 1)));
            endcase
            if (trig) begin
                run_seq(st, inj, (kind == 2) ? "R4" : (kind == 1) ? "R2" : "R3");
            end else begin
                repeat (3) @(negedge clk);
                chk_idle((kind == 2) ? "R4" : "R2");
            end
            pwr_fail = 1'b0;
            @(negedge clk);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule